// File: doc/BRIEF.md
# Replaying FIFO with Half-Full Flag

A single-clock first-in/first-out buffer for 9-bit words, sized by a power-of-two `DEPTH` parameter (at least 4). It has no address inputs. A write strobe stores the input word at an internal write location, and a read strobe takes the oldest stored word out. Both locations advance around a ring. The word width leaves room for a parity or control bit beside eight data bits.

Three status outputs are active low: full, empty, and more-than-half-full. An accepted read places its word on a registered data output, and a valid pulse marks the cycle it appears. An active-low replay input rewinds the read location to zero and leaves the write location as it is. Everything written since reset can then be read again, and the flags follow the new distance between the two locations. Any access that would overflow or underflow the buffer is dropped.

The fill level is tracked by a four-state machine: EMPTY, LOW (1 to DEPTH/2 words), HIGH (more than DEPTH/2 but fewer than DEPTH words) and FULL. Its transitions are:
- FILL_FIRST: EMPTY to LOW on a write.
- DRAIN_LAST: LOW to EMPTY when a read takes out the last word.
- CROSS_UP: LOW to HIGH when a write makes the count DEPTH/2+1.
- CROSS_DOWN: HIGH to LOW when a read brings the count back to DEPTH/2.
- TOP_OFF: HIGH to FULL when a write makes the count DEPTH.
- FREE_ONE: FULL to HIGH on a read.
- REPLAY: from any state to the class of the recomputed count.

A cycle with both a read and a write accepted keeps the current state.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `empty_n`=0, `full_n`=1, `half_n`=1 and `rd_valid`=0. Strobes held during reset have no effect.
- R2: A write is accepted only when `full_n`=1. A write strobe while full changes neither the stored words nor the write location, so later reads never return its data.
- R3: A read is accepted only when `empty_n`=0 is not the case (that is, `empty_n`=1). A read strobe while empty leaves `rd_valid`=0 and `rd_data` unchanged.
- R4: Starting from reset with no reads, `full_n` is still 1 after DEPTH-1 writes and goes to 0 after the DEPTH-th write.
- R5: One accepted write into an empty buffer drives `empty_n` to 1 in the following cycle. The read that takes out the last word drives `empty_n` to 0.
- R6: `half_n` goes to 0 after the write that takes the count from DEPTH/2 to DEPTH/2+1. It returns to 1 after the read that takes the count back to DEPTH/2.
- R7: A cycle with `replay_n`=0 sets the read location to zero and leaves the write location alone. Read and write strobes in that cycle are ignored. Provided no more than DEPTH writes have occurred since reset, the count afterwards equals the number of writes since reset, and the flags follow that count.
- R8: Words leave in the order they were written, all 9 bits intact. A read accepted at a clock edge puts its word on `rd_data` and sets `rd_valid`=1 for exactly the following cycle. `rd_data` holds its value otherwise.
- R9: A read and a write in the same cycle on a buffer that is neither empty nor full are both accepted. The count and all flags stay unchanged.
- R10: A read and a write in the same cycle on an empty buffer accept only the write. On a full buffer they accept only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Word to store |
| rd_stb | input | 1 | Read strobe, one word per cycle |
| replay_n | input | 1 | Rewind the read location to zero, active low |
| full_n | output | 1 | Low when DEPTH words are stored |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| rd_valid | output | 1 | High in the cycle after an accepted read |

## Verification
Every result takes exactly one register stage: the flags, `rd_data` and `rd_valid` all reflect a strobe or replay from the first rising edge after it. The bench drives inputs on the falling edge and compares every output on the next falling edge. The expected values come from a model that decides acceptance from its own count before the edge. At the edge cases (the last free slot, the half-way point, the last word, a replay after a partial drain, and a replay of a buffer that was filled and then emptied), the comparison falls in the cycle where the change is due. A flag that moves a cycle early or late is therefore reported.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

    // Fill-level classes held by the control state machine
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_FULL  = 2'd3
    } fill_state_e;

endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb,
    input  logic                        rd_stb,
    input  logic                        replay_n,
    input  logic [$clog2(DEPTH):0]      wr_count,
    output logic                        wr_go,
    output logic                        rd_go,
    output logic                        full_n,
    output logic                        empty_n,
    output logic                        half_n
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = AW + 1;
    localparam int HALF = DEPTH / 2;
    localparam logic [CW-1:0] C_DEPTH = CW'(DEPTH);
    localparam logic [CW-1:0] C_HALF  = CW'(HALF);
    localparam logic [CW-1:0] C_HALF1 = CW'(HALF + 1);
    localparam logic [CW-1:0] C_TOP   = CW'(DEPTH - 1);
    localparam logic [CW-1:0] C_ONE   = CW'(1);

    fill_state_e     state, state_nx;
    logic [CW-1:0]   occ, occ_nx, occ_rpl;

    function automatic fill_state_e classify(input logic [CW-1:0] n);
        if (n == '0)
            return ST_EMPTY;
        else if (n == C_DEPTH)
            return ST_FULL;
        else if (n > C_HALF)
            return ST_HIGH;
        else
            return ST_LOW;
    endfunction

    // Acceptance: blocked during replay, on full (write) and on empty (read)
    always_comb begin
        wr_go = replay_n && wr_stb && (state != ST_FULL);
        rd_go = replay_n && rd_stb && (state != ST_EMPTY);
    end

    // Count after a rewind: words written since reset, capped at DEPTH
    always_comb begin
        occ_rpl = (wr_count > C_DEPTH) ? C_DEPTH : wr_count;
    end

    always_comb begin
        occ_nx = occ;
        if (!replay_n)
            occ_nx = occ_rpl;
        else if (wr_go && !rd_go)
            occ_nx = occ + C_ONE;
        else if (rd_go && !wr_go)
            occ_nx = occ - C_ONE;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!replay_n) begin
            state_nx = classify(occ_rpl);                  // REPLAY
        end else begin
            unique case (state)
                ST_EMPTY: begin
                    if (wr_go)
                        state_nx = ST_LOW;                 // FILL_FIRST
                end
                ST_LOW: begin
                    if (wr_go && !rd_go && occ == C_HALF)
                        state_nx = ST_HIGH;                // CROSS_UP
                    else if (rd_go && !wr_go && occ == C_ONE)
                        state_nx = ST_EMPTY;               // DRAIN_LAST
                end
                ST_HIGH: begin
                    if (wr_go && !rd_go && occ == C_TOP)
                        state_nx = ST_FULL;                // TOP_OFF
                    else if (rd_go && !wr_go && occ == C_HALF1)
                        state_nx = ST_LOW;                 // CROSS_DOWN
                end
                ST_FULL: begin
                    if (rd_go)
                        state_nx = ST_HIGH;                // FREE_ONE
                end
                default: state_nx = ST_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            occ   <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
        end
    end

    // Output decode
    always_comb begin
        full_n  = 1'b1;
        empty_n = 1'b1;
        half_n  = 1'b1;
        unique case (state)
            ST_EMPTY: empty_n = 1'b0;
            ST_LOW:   ;
            ST_HIGH:  half_n  = 1'b0;
            ST_FULL: begin
                full_n = 1'b0;
                half_n = 1'b0;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/rf_ptrs.sv
module rf_ptrs #(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_go,
    input  logic                        rd_go,
    input  logic                        replay_n,
    output logic [$clog2(DEPTH):0]      wr_count,
    output logic [$clog2(DEPTH)-1:0]    wr_addr,
    output logic [$clog2(DEPTH)-1:0]    rd_addr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [CW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write ring pointer with one extra lap bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_go)
            wr_ptr <= wr_ptr + CW'(1);
    end

    // Read ring pointer; a replay cycle rewinds it to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (!replay_n)
            rd_ptr <= '0;
        else if (rd_go)
            rd_ptr <= rd_ptr + AW'(1);
    end

    always_comb begin
        wr_count = wr_ptr;
        wr_addr  = wr_ptr[AW-1:0];
        rd_addr  = rd_ptr;
    end

endmodule

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_go,
    input  logic [$clog2(DEPTH)-1:0]    wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_go,
    input  logic [$clog2(DEPTH)-1:0]    rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_valid
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go)
            mem[wr_addr] <= wr_data;
    end

    // Registered output; held between accepted reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              replay_n,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_go, rd_go;
    logic [AW:0]   wr_count;
    logic [AW-1:0] wr_addr, rd_addr;

    rf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .rd_stb   (rd_stb),
        .replay_n (replay_n),
        .wr_count (wr_count),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .full_n   (full_n),
        .empty_n  (empty_n),
        .half_n   (half_n)
    );

    rf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .replay_n (replay_n),
        .wr_count (wr_count),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr)
    );

    rf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_go    (wr_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              replay_n,
    input logic              full_n,
    input logic              empty_n,
    input logic              half_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    // R2: a lone write on a full buffer leaves it full
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_stb && !rd_stb && replay_n) |=> !full_n);

    // R3: a read on an empty buffer produces nothing and holds the data
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_stb) |=> (!rd_valid && $stable(rd_data)));

    // R5: a write into an empty buffer clears the empty flag
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wr_stb && replay_n) |=> empty_n);

    // R6: above half means neither empty nor at-most-half
    p_half_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n);

    // R4: full implies above half, never empty
    p_full_consistent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n));

    // R7: a replay cycle accepts no read
    p_replay_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !replay_n |=> !rd_valid);

    // R8: valid output follows only a read strobe
    p_valid_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb));

    // R9: simultaneous access on a partly filled buffer keeps the flags
    p_steady_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb && replay_n && full_n && empty_n)
        |=> ($stable(full_n) && $stable(empty_n) && $stable(half_n)));

    // R10: simultaneous access on an empty buffer takes only the write
    p_empty_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wr_stb && rd_stb && replay_n) |=> (empty_n && !rd_valid));

endmodule

bind replay_fifo rf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .replay_n (replay_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .half_n   (half_n),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/sim_replay_fifo.sv
`timescale 1ns/1ps
module sim_replay_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 9;
    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;
    localparam int NVEC  = 16;
    // Vector: [11]=write, [10]=read, [9]=replay_n, [8:0]=data
    localparam logic [11:0] VEC [NVEC] = '{
        12'hB01, 12'hAA2, 12'hBFF, 12'hE44, 12'h600, 12'hB55, 12'h600, 12'hCEE,
        12'h600, 12'h600, 12'hE33, 12'h600, 12'h600, 12'h600, 12'h600, 12'hA7C
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0, rd_stb = 1'b0, replay_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          full_n, empty_n, half_n, rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model
    logic [DW-1:0] mm [DEPTH];
    int            wc, rc;
    logic [DW-1:0] exp_q;
    bit            exp_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    replay_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .replay_n(replay_n), .full_n(full_n),
        .empty_n(empty_n), .half_n(half_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        int occ;
        occ = wc - rc;
        if (occ > DEPTH) occ = DEPTH;
        chk({tag, " empty_n"}, int'(empty_n), int'(occ != 0));
        chk({tag, " full_n"},  int'(full_n),  int'(occ != DEPTH));
        chk({tag, " half_n"},  int'(half_n),  int'(occ <= HALF));
        chk({tag, " rd_valid"}, int'(rd_valid), int'(exp_v));
        chk({tag, " rd_data"}, int'(rd_data), int'(exp_q));
    endtask

    // Called at a falling edge: drive, model, wait one cycle, compare
    task automatic step(input bit w, input bit r, input bit rpl_n,
                        input logic [DW-1:0] d, input string tag);
        int  occ;
        bit  aw, ar;
        occ = wc - rc;
        aw = w && rpl_n && (occ < DEPTH);
        ar = r && rpl_n && (occ > 0);
        wr_stb = w; rd_stb = r; replay_n = rpl_n; wr_data = d;
        exp_v = ar;
        if (ar) exp_q = mm[rc % DEPTH];
        if (aw) begin mm[wc % DEPTH] = d; wc++; end
        if (ar) rc++;
        if (!rpl_n) rc = 0;
        @(negedge clk);
        wr_stb = 0; rd_stb = 0; replay_n = 1;
        chk_all(tag);
    endtask

    task automatic do_reset(input bit busy);
        @(negedge clk);
        rst_n = 0;
        wr_stb = busy; rd_stb = busy; wr_data = 9'h1C3;
        @(negedge clk);
        chk("R1 reset empty_n", int'(empty_n), 0);
        chk("R1 reset full_n", int'(full_n), 1);
        chk("R1 reset half_n", int'(half_n), 1);
        chk("R1 reset rd_valid", int'(rd_valid), 0);
        @(negedge clk);
        wc = 0; rc = 0; exp_v = 0; exp_q = '0;
        wr_stb = 0; rd_stb = 0; rst_n = 1;
        @(negedge clk);
        chk_all("R1 after release");
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);

        // Table walk: mixed traffic and a replay (R8, R7, R9)
        for (int i = 0; i < NVEC; i++)
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:0], "R8 vector");
        step(0, 0, 1, '0, "R8 idle");

        // Fill to full from reset; half crossing on the way (R4, R6, R5)
        do_reset(1'b0);
        step(1, 0, 1, 9'h100, "R5 first write");
        for (int i = 1; i < DEPTH; i++) begin
            if (i == HALF)
                step(1, 0, 1, 9'(9'h100 + i), "R6 cross up");
            else
                step(1, 0, 1, 9'(9'h100 + i), "R4 fill");
        end
        chk("R4 full after DEPTH writes", int'(full_n), 0);
        step(1, 0, 1, 9'h0AA, "R2 write while full");
        step(1, 1, 1, 9'h0BB, "R10 pair on full");
        chk("R10 full pair took only read", int'(full_n), 1);

        // Drain, checking half crossing down and order (R8, R6, R5)
        while (wc - rc > 0)
            step(0, 1, 1, '0, (wc - rc == HALF + 1) ? "R6 cross down" : "R8 drain");
        chk("R5 empty after last read", int'(empty_n), 0);
        step(0, 1, 1, '0, "R3 read while empty");
        step(1, 1, 1, 9'h0CC, "R10 pair on empty");
        step(0, 1, 1, '0, "R10 only write taken");

        // Steady flags at the half boundary (R9)
        for (int i = 0; i < HALF + 1; i++)
            step(1, 0, 1, 9'(9'h050 + i), "R6 refill");
        step(1, 1, 1, 9'h0DD, "R9 pair above half");
        step(1, 1, 1, 9'h0EE, "R9 pair again");

        // Replay after a partial drain (R7)
        do_reset(1'b0);
        for (int i = 0; i < 6; i++)
            step(1, 0, 1, 9'(9'h1E0 + i), "R7 load");
        for (int i = 0; i < 3; i++)
            step(0, 1, 1, '0, "R7 partial drain");
        step(1, 1, 0, 9'h011, "R7 replay with strobes");
        chk("R7 replay count above half", int'(half_n), 0);
        for (int i = 0; i < 6; i++)
            step(0, 1, 1, '0, "R7 replayed order");
        chk("R7 drained after replay", int'(empty_n), 0);

        // Replay after filling to DEPTH and emptying (R7, R4)
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, 1, 9'(9'h0F0 + i), "R4 load full");
        for (int i = 0; i < DEPTH; i++)
            step(0, 1, 1, '0, "R8 drain all");
        step(0, 0, 0, '0, "R7 replay to full");
        chk("R7 full after replay", int'(full_n), 0);
        step(0, 1, 1, '0, "R7 first replayed word");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule